// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and date in packed BCD registers: seconds, minutes, hours (24-hour), day of month, weekday (0 is Sunday), month and a two-digit year, plus a century flag carried in the month register. A sub-second prescaler counts pulses of a reference enable, nominally at 32.768 kHz, and produces one advance per second. A BCD carry chain then ripples through the fields, and the day field honours each month's length, including leap Februaries.

Software loads the fields through a simple write port and reads them back through a combinational read port. A stop control freezes all counting while a new time is loaded. Releasing the stop restarts the prescaler from zero, so the first second after release is a full one. A sticky flag in bit 7 of the seconds register is set by reset, modelling power loss, and stays set until software writes the seconds register. A write cycle has priority: a one-second advance that falls in the same cycle as any write is dropped.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset, the seconds register reads 0x80 (bit 7 is the not-valid flag, value 00). Minutes, hours, weekday, year and control read 0x00. Day reads 0x01. Month reads 0x01, with the century flag in bit 7 clear.
- R2: The control register is at address 0x00, and bit 5 of it is stop. The time registers are at 0x02 seconds, 0x03 minutes, 0x04 hours, 0x05 day, 0x06 weekday, 0x07 month and 0x08 year. Written data is masked to 0x7F for seconds and minutes, 0x3F for hours and day, 0x07 for weekday, 0x9F for month (bit 7 is century) and 0xFF for year. Every other address reads 0x00.
- R3: Writing the seconds register clears the not-valid flag, whatever bit 7 of the written data holds. Writing any other register leaves the flag unchanged, and only reset sets it.
- R4: While stop is 1, no time field changes, however many reference enables arrive.
- R5: After stop is cleared, the seconds field advances on the clock edge that takes the PRESCALE-th reference enable following the release. Cycles without an enable are not counted.
- R6: The fields advance in BCD. Seconds go from 59 to 00 and carry into minutes. Minutes go from 59 to 00 and carry into hours. Hours go from 23 to 00 and carry into the day.
- R7: Each day carry advances the weekday, which wraps from 6 to 0.
- R8: The day wraps to 01 and carries into the month after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. In February it wraps after day 29 when the year's value is divisible by 4 (year 00 counts as divisible), and after day 28 otherwise.
- R9: Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00 and inverts the century flag.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle enable per reference oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Register read data (combinational) |

## Verification
Directed loads placed one second before a boundary separate the carry stages. A minute rollover exercises only the seconds carry. A year-end load drives every field and the century flag in one step. February loads in leap and non-leap years, and 30-day and 31-day month ends, tell the month-length selection apart. Random loads run for random stretches of seconds and compare every field with a calendar model kept in the bench. A release with the enable held high, and another with gaps in the enable, separate counting of reference pulses from counting of clock cycles. A long stopped interval shows the freeze.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam logic [7:0] ADR_CTRL = 8'h00;
    localparam logic [7:0] ADR_SEC  = 8'h02;
    localparam logic [7:0] ADR_MIN  = 8'h03;
    localparam logic [7:0] ADR_HOUR = 8'h04;
    localparam logic [7:0] ADR_DAY  = 8'h05;
    localparam logic [7:0] ADR_WDAY = 8'h06;
    localparam logic [7:0] ADR_MON  = 8'h07;
    localparam logic [7:0] ADR_YEAR = 8'h08;

    localparam int STOP_BIT = 5;

    typedef struct packed {
        logic       stop;
        logic       bad;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] day;
        logic [2:0] wday;
        logic       cent;
        logic [4:0] mon;
        logic [7:0] year;
    } cal_state_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_en,
    input  logic hold,
    output logic tick
);
    localparam int CNT_W = $clog2(PRESCALE + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = !hold && ref_en && (cnt_q == LIM);
        cnt_d = cnt_q;
        if (hold)
            cnt_d = '0;
        else if (ref_en)
            cnt_d = (cnt_q == LIM) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !tick); // R4
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [4:0] mon,
    input  logic [7:0] year,
    output logic [5:0] last_day
);
    logic [7:0] year_bin;
    logic       leap;
    logic       short_month;

    always_comb begin
        year_bin    = ({4'd0, year[7:4]} * 8'd10) + {4'd0, year[3:0]};
        leap        = (year_bin[1:0] == 2'b00);
        short_month = (mon == 5'h04) || (mon == 5'h06) ||
                      (mon == 5'h09) || (mon == 5'h11);
        if (mon == 5'h02)
            last_day = leap ? 6'h29 : 6'h28;
        else if (short_month)
            last_day = 6'h30;
        else
            last_day = 6'h31;
    end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
    import cal_pkg::*;
#(
    parameter int PRESCALE = 32768,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    cal_state_t st_d, st_q;
    logic       tick;
    logic       adv;
    logic [5:0] last_day;
    logic       c_sec, c_min, c_hour, c_day, c_mon, c_year;

    cal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_en),
        .hold   (st_q.stop),
        .tick   (tick)
    );

    cal_month_len u_mlen (
        .mon      (st_q.mon),
        .year     (st_q.year),
        .last_day (last_day)
    );

    always_comb begin
        st_d   = st_q;
        adv    = tick && !wr_en;
        c_sec  = st_q.sec  >= 7'h59;
        c_min  = st_q.min  >= 7'h59;
        c_hour = st_q.hour >= 6'h23;
        c_day  = st_q.day  >= last_day;
        c_mon  = st_q.mon  >= 5'h12;
        c_year = st_q.year >= 8'h99;

        if (adv) begin
            st_d.sec = c_sec ? 7'h00 : 7'(bcd_inc({1'b0, st_q.sec}));
            if (c_sec) begin
                st_d.min = c_min ? 7'h00 : 7'(bcd_inc({1'b0, st_q.min}));
                if (c_min) begin
                    st_d.hour = c_hour ? 6'h00 : 6'(bcd_inc({2'b0, st_q.hour}));
                    if (c_hour) begin
                        st_d.wday = (st_q.wday >= 3'd6) ? 3'd0 : st_q.wday + 3'd1;
                        st_d.day  = c_day ? 6'h01 : 6'(bcd_inc({2'b0, st_q.day}));
                        if (c_day) begin
                            st_d.mon = c_mon ? 5'h01 : 5'(bcd_inc({3'b0, st_q.mon}));
                            if (c_mon) begin
                                st_d.year = c_year ? 8'h00 : bcd_inc(st_q.year);
                                if (c_year)
                                    st_d.cent = !st_q.cent;
                            end
                        end
                    end
                end
            end
        end

        if (wr_en) begin
            case (8'(wr_addr))
                ADR_CTRL: st_d.stop = wr_data[STOP_BIT];
                ADR_SEC:  begin st_d.sec = wr_data[6:0]; st_d.bad = 1'b0; end
                ADR_MIN:  st_d.min  = wr_data[6:0];
                ADR_HOUR: st_d.hour = wr_data[5:0];
                ADR_DAY:  st_d.day  = wr_data[5:0];
                ADR_WDAY: st_d.wday = wr_data[2:0];
                ADR_MON:  begin st_d.mon = wr_data[4:0]; st_d.cent = wr_data[7]; end
                ADR_YEAR: st_d.year = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.bad  <= 1'b1;
            st_q.day  <= 6'h01;
            st_q.mon  <= 5'h01;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (8'(rd_addr))
            ADR_CTRL: rd_data = 8'(st_q.stop) << STOP_BIT;
            ADR_SEC:  rd_data = {st_q.bad, st_q.sec};
            ADR_MIN:  rd_data = {1'b0, st_q.min};
            ADR_HOUR: rd_data = {2'b0, st_q.hour};
            ADR_DAY:  rd_data = {2'b0, st_q.day};
            ADR_WDAY: rd_data = {5'b0, st_q.wday};
            ADR_MON:  rd_data = {st_q.cent, 2'b0, st_q.mon};
            ADR_YEAR: rd_data = st_q.year;
            default:  rd_data = 8'h00;
        endcase
    end

    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(st_q.bad)); // R3
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop && !wr_en) |=> $stable({st_q.sec, st_q.min, st_q.hour, st_q.day,
                                            st_q.wday, st_q.mon, st_q.year, st_q.cent})); // R4
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st_q.sec == 7'h59) |=> (st_q.sec == 7'h00)); // R6
    AST_MIN_NEEDS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.min) && !$past(wr_en)) |-> ($past(st_q.sec) == 7'h59)); // R6
    AST_CENT_ON_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.cent) && !$past(wr_en)) |-> ($past(st_q.year) == 8'h99)); // R9
endmodule

// File: tb/sim_bcd_calendar_core.sv
module sim_bcd_calendar_core;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    int m_sec, m_min, m_hour, m_day, m_wday, m_mon, m_year, m_cent;

    always #2 clk = ~clk;

    bcd_calendar_core #(.PRESCALE(P), .ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mlen(input int mon, input int year);
        if (mon == 2) return (year % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hour++;
                if (m_hour == 24) begin
                    m_hour = 0;
                    m_wday = (m_wday + 1) % 7;
                    m_day++;
                    if (m_day > mlen(m_mon, m_year)) begin
                        m_day = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_year++;
                            if (m_year == 100) begin
                                m_year = 0; m_cent = 1 - m_cent;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0h actual %02h expected %02h", tag, a, rd_data, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int s, input int mi, input int h, input int d,
                        input int w, input int mo, input int y, input int c);
        wr(4'h0, 8'h20);
        wr(4'h2, to_bcd(s));
        wr(4'h3, to_bcd(mi));
        wr(4'h4, to_bcd(h));
        wr(4'h5, to_bcd(d));
        wr(4'h6, to_bcd(w));
        wr(4'h7, to_bcd(mo) | (c != 0 ? 8'h80 : 8'h00));
        wr(4'h8, to_bcd(y));
        m_sec = s; m_min = mi; m_hour = h; m_day = d;
        m_wday = w; m_mon = mo; m_year = y; m_cent = c;
    endtask

    task automatic check_all(input string tag);
        chk(4'h2, to_bcd(m_sec), tag);
        chk(4'h3, to_bcd(m_min), tag);
        chk(4'h4, to_bcd(m_hour), tag);
        chk(4'h5, to_bcd(m_day), tag);
        chk(4'h6, to_bcd(m_wday), tag);
        chk(4'h7, to_bcd(m_mon) | (m_cent != 0 ? 8'h80 : 8'h00), tag);
        chk(4'h8, to_bcd(m_year), tag);
    endtask

    task automatic run(input int n, input string tag);
        wr(4'h0, 8'h00);
        repeat (P * n) @(negedge clk);
        wr(4'h0, 8'h20);
        for (int i = 0; i < n; i++) model_step();
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240229));
        ref_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(4'h2, 8'h80, "R1 seconds");
        chk(4'h3, 8'h00, "R1 minutes");
        chk(4'h4, 8'h00, "R1 hours");
        chk(4'h5, 8'h01, "R1 day");
        chk(4'h6, 8'h00, "R1 weekday");
        chk(4'h7, 8'h01, "R1 month");
        chk(4'h8, 8'h00, "R1 year");
        chk(4'h0, 8'h00, "R1 control");
        // R2 control and unused addresses
        wr(4'h0, 8'hFF);
        chk(4'h0, 8'h20, "R2 control stop only");
        chk(4'h1, 8'h00, "R2 unused 1");
        chk(4'h9, 8'h00, "R2 unused 9");
        // R3 flag survives other writes, cleared by seconds write
        wr(4'h3, 8'h12);
        chk(4'h2, 8'h80, "R3 flag kept");
        wr(4'h2, 8'hA5);
        chk(4'h2, 8'h25, "R3 flag cleared");
        // R2 masks
        wr(4'h4, 8'hFF); chk(4'h4, 8'h3F, "R2 hour mask");
        wr(4'h6, 8'hFE); chk(4'h6, 8'h06, "R2 weekday mask");
        wr(4'h7, 8'hF2); chk(4'h7, 8'h92, "R2 month mask");
        wr(4'h5, 8'hFF); chk(4'h5, 8'h3F, "R2 day mask");
        wr(4'h3, 8'hFF); chk(4'h3, 8'h7F, "R2 minute mask");
        wr(4'h8, 8'hFF); chk(4'h8, 8'hFF, "R2 year mask");
        ref_en = 1'b1;
        // R4 freeze while stopped
        load(10, 20, 5, 14, 3, 7, 21, 0);
        repeat (40) @(negedge clk);
        check_all("R4 frozen");
        // R5 exact release timing
        wr(4'h0, 8'h00);
        repeat (P - 1) @(negedge clk);
        chk(4'h2, to_bcd(10), "R5 before full second");
        @(negedge clk);
        chk(4'h2, to_bcd(11), "R5 full second");
        wr(4'h0, 8'h20);
        // R5 gaps in the enable are not counted
        load(30, 0, 0, 1, 0, 1, 0, 0);
        wr(4'h0, 8'h00);
        ref_en = 1'b0;
        repeat (6) @(negedge clk);
        chk(4'h2, to_bcd(30), "R5 no enables");
        ref_en = 1'b1;
        repeat (P - 1) @(negedge clk);
        chk(4'h2, to_bcd(30), "R5 partial");
        @(negedge clk);
        chk(4'h2, to_bcd(31), "R5 counted enables");
        wr(4'h0, 8'h20);
        // R6 carries
        load(59, 0, 0, 1, 0, 1, 0, 0);    run(1, "R6 minute carry");
        load(59, 59, 7, 1, 0, 1, 0, 0);   run(1, "R6 hour carry");
        load(58, 59, 23, 9, 2, 3, 5, 0);  run(3, "R6 day carry");
        // R7 weekday wrap
        load(59, 59, 23, 10, 6, 3, 5, 0); run(1, "R7 weekday wrap");
        // R8 month lengths
        load(59, 59, 23, 28, 1, 2, 24, 0); run(1, "R8 leap Feb 28");
        load(59, 59, 23, 29, 1, 2, 24, 0); run(1, "R8 leap Feb 29");
        load(59, 59, 23, 28, 1, 2, 23, 0); run(1, "R8 plain Feb 28");
        load(59, 59, 23, 28, 1, 2, 0, 1);  run(1, "R8 year 00 Feb");
        load(59, 59, 23, 30, 1, 4, 23, 0); run(1, "R8 April end");
        load(59, 59, 23, 30, 1, 11, 23, 0); run(1, "R8 November end");
        load(59, 59, 23, 30, 1, 1, 23, 0); run(1, "R8 January 30");
        load(59, 59, 23, 31, 1, 1, 23, 0); run(1, "R8 January end");
        // R9 year and century
        load(59, 59, 23, 31, 6, 12, 41, 0); run(1, "R9 year carry");
        load(59, 59, 23, 31, 6, 12, 99, 0); run(1, "R9 century set");
        load(59, 59, 23, 31, 2, 12, 99, 1); run(1, "R9 century clear");
        // random loads and runs
        for (int it = 0; it < 24; it++) begin
            int mo, y, s;
            mo = int'($urandom_range(1, 12));
            y  = int'($urandom_range(0, 99));
            s  = (it % 3 == 0) ? int'($urandom_range(50, 59)) : int'($urandom_range(0, 59));
            load(s, int'($urandom_range(0, 59)), int'($urandom_range(0, 23)),
                 int'($urandom_range(1, mlen(mo, y))), int'($urandom_range(0, 6)),
                 mo, y, int'($urandom_range(0, 1)));
            run(int'($urandom_range(1, 300)), "R6 R8 random run");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule